// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Generator

This block drives a byte-wide parallel output whose bits change only on trigger events. An internal up-counter runs while enabled. It returns to zero when it equals a programmable period value, and each such compare match is a timing event. On a trigger, a staged "next pattern" value is copied into the output register. Only the bits that a per-bit enable mask allows are copied. The other bits keep their value.

The output is split into nibble-wide groups. Each group has its own 2-bit source selector: the local compare match, an external trigger strobe, or none. A compare match also sets an event flag, and that flag can raise an interrupt. Software or a DMA engine uses the interrupt to load the next pattern before the following match. This produces jitter-free stepping sequences, such as overlapping multi-phase motor drive patterns.

The registers are written through a simple write strobe port. The flag is cleared by a write-one-to-clear access or by a DMA acknowledge strobe.

Top module: `pattern_pulse_gen`

## Requirements
- R1: After reset, `pat_out` is 0x00 and `irq` is 0. The enable mask, control and next-pattern registers all reset to zero.
- R2: Write addresses are: 0 for the period, 1 for the next pattern, 2 for the enable mask, 3 for control, and 4 for flag clear. In control, bit 0 is run and bit 1 is interrupt enable. While run is 1, a period of N produces a compare match every N+1 clocks. While run is 0, the counter holds and no match occurs.
- R3: On a trigger for a group, each output bit of that group whose mask bit is 1 takes the next-pattern bit. Each bit whose mask bit is 0 keeps its value. The output is updated at the clock edge of the trigger.
- R4: Writing the next-pattern register does not change `pat_out` until a later trigger.
- R5: Control bits [3:2] select the source for output bits [3:0], and bits [5:4] select the source for bits [7:4]. Code 0 is the local compare match, code 1 is the `ext_trig` input, and codes 2 and 3 never update the group.
- R6: A compare match sets the event flag. `irq` is high exactly while the flag is set and the interrupt-enable bit is 1.
- R7: The flag is cleared by writing 1 to bit 0 at address 4, or by `dma_ack`. If a clear and a match fall in the same cycle, the flag stays set.
- R8: With mask 0xF8 and the cycle 0x80, 0xC0, 0x40, 0x60, 0x20, 0x30, 0x10, 0x18, 0x08, 0x88 loaded one value per match, the output steps through those values. Each step has one or two bits high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W (16) | Register write data |
| ext_trig | input | 1 | External trigger strobe for groups set to code 1 |
| dma_ack | input | 1 | Clears the event flag |
| pat_out | output | PAT_W (8) | Pattern output |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can collide in one cycle: a flag clear and a new compare match. To provoke this, the bench holds `dma_ack` high across three full match periods, so every match coincides with an active clear. Over a window of 15 cycles with a period of 4, `irq` must be seen high exactly three times, one cycle after each match. If clearing took priority, the count would be zero. A second overlap is a next-pattern load racing the match. The scoreboard reloads the next pattern within two cycles of each serviced match, and each queued expected value must appear at the following match.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef enum logic [1:0] {
    SRC_TIMER = 2'd0,
    SRC_EXT   = 2'd1,
    SRC_NONE2 = 2'd2,
    SRC_NONE3 = 2'd3
  } trig_src_e;

  localparam logic [2:0] ADDR_PERIOD = 3'd0;
  localparam logic [2:0] ADDR_NEXT   = 3'd1;
  localparam logic [2:0] ADDR_MASK   = 3'd2;
  localparam logic [2:0] ADDR_CTRL   = 3'd3;
  localparam logic [2:0] ADDR_CLR    = 3'd4;

  // Decode of one group's source selector into a trigger pulse.
  function automatic logic src_fires(input logic [1:0] sel,
                                     input logic tmr_evt,
                                     input logic ext_evt);
    case (trig_src_e'(sel))
      SRC_TIMER: src_fires = tmr_evt;
      SRC_EXT:   src_fires = ext_evt;
      default:   src_fires = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ppg_regs.sv
module ppg_regs #(
  parameter int PAT_W  = 8,
  parameter int CNT_W  = 16,
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  period,
  output logic [PAT_W-1:0]  nxt,
  output logic [PAT_W-1:0]  mask,
  output logic [CTRL_W-1:0] ctrl,
  output logic              clr_pulse
);
  import ppg_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= '0;
      nxt    <= '0;
      mask   <= '0;
      ctrl   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_PERIOD: period <= wr_data;
        ADDR_NEXT:   nxt    <= wr_data[PAT_W-1:0];
        ADDR_MASK:   mask   <= wr_data[PAT_W-1:0];
        ADDR_CTRL:   ctrl   <= wr_data[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_pulse = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  assign match = run && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (match) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ppg_group.sv
module ppg_group #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] en,
  output logic [W-1:0] q
);
  // Enabled bits take the staged value; the rest keep the present output.
  function automatic logic [W-1:0] merge(input logic [W-1:0] cur,
                                         input logic [W-1:0] stage,
                                         input logic [W-1:0] sel);
    merge = (cur & ~sel) | (stage & sel);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (trig) q <= merge(q, nxt, en);
  end

endmodule

// File: rtl/pattern_pulse_gen.sv
module pattern_pulse_gen #(
  parameter int PAT_W = 8,
  parameter int CNT_W = 16,
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_trig,
  input  logic             dma_ack,
  output logic [PAT_W-1:0] pat_out,
  output logic             irq
);
  localparam int NGRP   = PAT_W / GRP_W;
  localparam int CTRL_W = 2 + 2 * NGRP;

  logic [CNT_W-1:0]  period;
  logic [PAT_W-1:0]  nxt_q;
  logic [PAT_W-1:0]  mask_q;
  logic [CTRL_W-1:0] ctrl;
  logic              clr_pulse;
  logic              run;
  logic              irq_en;
  logic [CNT_W-1:0]  tmr_cnt;
  logic              tmr_match;
  logic [NGRP-1:0]   trig_vec;
  logic              flag_q;

  ppg_regs #(.PAT_W(PAT_W), .CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period(period), .nxt(nxt_q), .mask(mask_q),
    .ctrl(ctrl), .clr_pulse(clr_pulse)
  );

  assign run    = ctrl[0];
  assign irq_en = ctrl[1];

  ppg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period),
    .cnt(tmr_cnt), .match(tmr_match)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign trig_vec[g] = ppg_pkg::src_fires(ctrl[2+2*g +: 2], tmr_match, ext_trig);

    ppg_group #(.W(GRP_W)) u_grp (
      .clk(clk), .rst_n(rst_n), .trig(trig_vec[g]),
      .nxt(nxt_q[g*GRP_W +: GRP_W]), .en(mask_q[g*GRP_W +: GRP_W]),
      .q(pat_out[g*GRP_W +: GRP_W])
    );
  end

  // A new match outranks a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= tmr_match | (flag_q & ~(clr_pulse | dma_ack));
  end

  assign irq = flag_q & irq_en;

endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
  parameter int PAT_W = 8,
  parameter int CNT_W = 16,
  parameter int NGRP  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             match,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             irq_en,
  input logic             irq,
  input logic [PAT_W-1:0] pat_out,
  input logic [PAT_W-1:0] mask,
  input logic [NGRP-1:0]  trig_vec
);

  p_match_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt == '0));

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((pat_out ^ $past(pat_out)) & ~$past(mask)) == '0));

  p_no_trig_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|trig_vec) |=> $stable(pat_out));

  p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq |-> (flag && irq_en)));

  p_match_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);

endmodule

bind pattern_pulse_gen ppg_checker #(.PAT_W(PAT_W), .CNT_W(CNT_W), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .match(tmr_match), .cnt(tmr_cnt),
  .flag(flag_q), .irq_en(irq_en), .irq(irq), .pat_out(pat_out),
  .mask(mask_q), .trig_vec(trig_vec)
);

// File: tb/pattern_pulse_gen_bench.sv
`timescale 1ns/1ps
module pattern_pulse_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ext_trig = 1'b0;
  logic        drv_ack = 1'b0;
  logic        mon_ack = 1'b0;
  logic        dma_ack;
  logic [7:0]  pat_out;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int pops    = 0;
  int cyc     = 0;
  bit mon_en  = 1'b0;
  logic [7:0] exp_q[$];

  assign dma_ack = drv_ack | mon_ack;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pattern_pulse_gen u_pattern_pulse_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_trig(ext_trig), .dma_ack(dma_ack),
    .pat_out(pat_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: on each serviced event pop the expected pattern and acknowledge.
  always @(negedge clk) begin
    mon_ack <= 1'b0;
    if (mon_en && irq && !mon_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 queue empty", {24'd0, pat_out}, 32'd0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(pat_out == e, "R8 step value", {24'd0, pat_out}, {24'd0, e});
        chk(($countones(pat_out) >= 1) && ($countones(pat_out) <= 2),
            "R8 phases active", $countones(pat_out), 32'd2);
      end
      pops <= pops + 1;
      mon_ack <= 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] seq [10] = '{8'h80, 8'hC0, 8'h40, 8'h60, 8'h20,
                             8'h30, 8'h10, 8'h18, 8'h08, 8'h88};
    logic [7:0] old_v;
    int t0, t1, hits;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pat_out == 8'h00, "R1 output", {24'd0, pat_out}, 32'h0);
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    repeat (5) @(negedge clk);
    chk(pat_out == 8'h00, "R1 output held", {24'd0, pat_out}, 32'h0);

    // R8 / R3: five-phase sequence through the scoreboard
    wr(3'd0, 16'd9);
    wr(3'd2, 16'h00F8);
    wr(3'd1, {8'd0, seq[0]});
    exp_q.push_back(seq[0]);
    mon_en = 1'b1;
    wr(3'd3, 16'h0003);
    for (int i = 1; i < 20; i++) begin
      wait (pops == i);
      wr(3'd1, {8'd0, seq[i % 10]});
      exp_q.push_back(seq[i % 10]);
    end
    wait (pops == 20);
    wr(3'd3, 16'h0000);
    mon_en = 1'b0;
    repeat (2) @(negedge clk);

    // R4: staged write with no trigger
    wr(3'd1, 16'h0055);
    repeat (12) @(negedge clk);
    chk(pat_out == 8'h88, "R4 staged write no effect", {24'd0, pat_out}, 32'h88);
    chk(irq == 1'b0, "R2 no match while stopped", {31'd0, irq}, 32'd0);

    // R5: external trigger for low group, none for high group
    wr(3'd2, 16'h00FF);
    wr(3'd1, 16'h003C);
    wr(3'd3, 16'h0024);
    @(negedge clk) ext_trig = 1'b1;
    @(negedge clk) ext_trig = 1'b0;
    @(negedge clk);
    chk(pat_out == 8'h8C, "R5 ext source low group", {24'd0, pat_out}, 32'h8C);
    wr(3'd0, 16'd4);
    wr(3'd3, 16'h003B);
    repeat (15) @(negedge clk);
    chk(pat_out == 8'h8C, "R5 unimplemented codes", {24'd0, pat_out}, 32'h8C);
    chk(irq == 1'b1, "R6 match sets flag", {31'd0, irq}, 32'd1);
    wr(3'd3, 16'h000B);
    repeat (8) @(negedge clk);
    chk(pat_out == 8'h3C, "R5 timer source high group", {24'd0, pat_out}, 32'h3C);

    // R3: partial mask
    old_v = pat_out;
    wr(3'd2, 16'h003C);
    wr(3'd1, 16'h00A5);
    wr(3'd3, 16'h0003);
    repeat (8) @(negedge clk);
    chk(pat_out == ((old_v & ~8'h3C) | (8'hA5 & 8'h3C)), "R3 mask merge",
        {24'd0, pat_out}, {24'd0, (old_v & ~8'h3C) | (8'hA5 & 8'h3C)});

    // R2: match spacing with period 4
    wr(3'd4, 16'h0001);
    do @(negedge clk); while (!irq);
    t0 = cyc;
    wr(3'd4, 16'h0001);
    do @(negedge clk); while (!irq);
    t1 = cyc;
    chk((t1 - t0) == 5, "R2 period N gives N+1", t1 - t0, 32'd5);

    wr(3'd3, 16'h0002);
    wr(3'd4, 16'h0001);
    repeat (20) @(negedge clk);
    chk(irq == 1'b0, "R2 counter holds when stopped", {31'd0, irq}, 32'd0);

    // R6: interrupt enable gating
    wr(3'd3, 16'h0001);
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R6 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd3, 16'h0003);
    chk(irq == 1'b1, "R6 irq after enable", {31'd0, irq}, 32'd1);

    // R7: clear held against matches; match wins
    wr(3'd4, 16'h0001);
    @(negedge clk) drv_ack = 1'b1;
    @(negedge clk);
    hits = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (irq) hits++;
    end
    drv_ack = 1'b0;
    chk(hits == 3, "R7 match beats clear", hits, 32'd3);

    wr(3'd3, 16'h0002);
    wr(3'd4, 16'h0001);
    chk(irq == 1'b0, "R7 write-one clear", {31'd0, irq}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule